// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This unit is the interrupt end of a single general-purpose pin. It takes the pin's already filtered input level and a 32-bit pin register. Software writes that register and reads it back. From the register's control fields the unit picks a trigger condition: a rising edge, a falling edge, either edge, a high level or a low level. When that condition is detected, the unit latches an interrupt status bit and a wake status bit, and it raises a pending output toward the interrupt collector.

Two status cells hold the latched state. Each cell is a two-state machine. In `STS_CLEAR` it moves to `STS_HELD` when a trigger arrives and its enable is set. In `STS_HELD` it returns to `STS_CLEAR` when software writes a one to its bit and no trigger is present in that same cycle. A trigger always wins over a clear. Because of this, a level-sensitive source that is still active cannot be cleared.

The trigger decoder turns the level/edge select and the polarity field into one of six modes: `TRIG_NONE`, `TRIG_RISE`, `TRIG_FALL`, `TRIG_BOTH`, `TRIG_HIGH` and `TRIG_LOW`. Edge modes compare the input with a copy of it registered one cycle earlier. The same register also controls the pad's output enable and output value. Its readback includes a pin-level bit.

Top module: `gpio_pin_irq_unit`

## Requirements
- R1: After reset, the whole readback word is zero, `pending` is 0 and `pad_oe` is 0.
- R2: Bit 0 = 0 selects edge mode. In edge mode, polarity field bits [2:1] = 0 sets interrupt status (bit 12) one clock after the input goes 0 to 1. A 1-to-0 change, or a steady input, does not set it.
- R3: In edge mode, polarity 1 sets interrupt status only on a 1-to-0 input change.
- R4: In edge mode, polarity 2 sets interrupt status on any input change.
- R5: Bit 0 = 1 selects level mode. In level mode, polarity 0 (active high) or 1 (active low) sets status on every clock where the input is at its active level. A write-one-to-clear issued while the input is still active leaves the status at 1.
- R6: In level mode, polarity 2 never sets status. Polarity 3 never sets status in either mode.
- R7: Interrupt status is latched only while the interrupt enable (bit 3) is 1. Clearing the enable leaves a latched status in place.
- R8: `pending` is 1 exactly when bit 12 or bit 13 is set and the unmask bit (bit 4) is 1.
- R9: Writing 1 to bit 12 clears interrupt status when no trigger is present. Writing 0 to bit 12 leaves it unchanged.
- R10: With wake enable (bit 7) set, a trigger sets wake status (bit 13) even when interrupt enable is 0. Writing 1 to bit 13 clears it.
- R11: `pad_oe` follows output enable (bit 5) and `pad_out` follows output value (bit 6). Readback bit 8 shows the output value when output enable is 1 and `pin_in` otherwise.
- R12: Bits [7:0] read back as last written. Bit 8 and bits 9–11 and 14–31 are read-only and ignore writes. Those bits other than bit 8 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Filtered input level of the pin |
| wr_en | input | 1 | Write strobe for the pin register |
| wr_data | input | 32 | Write data: control bits [7:0], clear strobes at bits 12–13 |
| rd_data | output | 32 | Pin register readback |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| pending | output | 1 | Unmasked interrupt or wake pending |

## Verification
A wrong mode decode, or a stale registered copy of the input, shows at bit 12 and on `pending` one clock after the input step that should, or should not, have triggered. Sweeping every encoding against every pair of consecutive input levels therefore exposes such a fault within two cycles. A status cell stuck in the wrong state shows as soon as it is read back after a write-one-to-clear, or after an enable change. The bench reads the status immediately after each write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int REG_W      = 32;
    localparam int PIN_BIT    = 8;
    localparam int ISTS_BIT   = 12;
    localparam int NUM_STS    = 2;

    typedef enum logic [1:0] {
        POL_HIGH = 2'd0,
        POL_LOW  = 2'd1,
        POL_BOTH = 2'd2,
        POL_RSVD = 2'd3
    } pol_e;

    // packed so that bit 0 is the level select and bit 7 the wake enable
    typedef struct packed {
        logic wake_en;
        logic out_val;
        logic out_en;
        logic unmask;
        logic irq_en;
        pol_e pol;
        logic level;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        TRIG_NONE,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH,
        TRIG_HIGH,
        TRIG_LOW
    } trig_e;

    typedef enum logic {
        STS_CLEAR,
        STS_HELD
    } sts_e;
endpackage

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic pin_in,
    output logic hit
);
    logic  prev_q;
    trig_e mode;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_in;
    end

    always_comb begin
        mode = TRIG_NONE;
        if (cfg.level) begin
            unique case (cfg.pol)
                POL_HIGH: mode = TRIG_HIGH;
                POL_LOW:  mode = TRIG_LOW;
                POL_BOTH: mode = TRIG_NONE;
                POL_RSVD: mode = TRIG_NONE;
            endcase
        end else begin
            unique case (cfg.pol)
                POL_HIGH: mode = TRIG_RISE;
                POL_LOW:  mode = TRIG_FALL;
                POL_BOTH: mode = TRIG_BOTH;
                POL_RSVD: mode = TRIG_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            TRIG_RISE: hit = pin_in & ~prev_q;
            TRIG_FALL: hit = ~pin_in & prev_q;
            TRIG_BOTH: hit = pin_in ^ prev_q;
            TRIG_HIGH: hit = pin_in;
            TRIG_LOW:  hit = ~pin_in;
            default:   hit = 1'b0;
        endcase
    end

    // R6
    both_in_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && cfg.pol == POL_BOTH) |-> !hit);

    // R2
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && cfg.pol == POL_HIGH && !pin_in) |-> !hit);
endmodule

// File: rtl/gpio_sts_cell.sv
module gpio_sts_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic sts
);
    sts_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STS_CLEAR: if (set_req)              state_d = STS_HELD;
            STS_HELD:  if (clr_req && !set_req)  state_d = STS_CLEAR;
        endcase
    end

    always_comb sts = (state_q == STS_HELD);

    // R9
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && clr_req && !set_req) |=> !sts);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> sts);
endmodule

// File: rtl/gpio_pin_irq_unit.sv
module gpio_pin_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pending
);
    cfg_t               cfg_q;
    logic               hit;
    logic [NUM_STS-1:0] set_vec;
    logic [NUM_STS-1:0] clr_vec;
    logic [NUM_STS-1:0] sts_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    gpio_trig_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg_q),
        .pin_in (pin_in),
        .hit    (hit)
    );

    assign set_vec[0] = hit & cfg_q.irq_en;
    assign set_vec[1] = hit & cfg_q.wake_en;

    for (genvar i = 0; i < NUM_STS; i++) begin : g_sts
        assign clr_vec[i] = wr_en & wr_data[ISTS_BIT+i];
        gpio_sts_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_vec[i]),
            .clr_req (clr_vec[i]),
            .sts     (sts_vec[i])
        );
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[CFG_W-1:0]           = cfg_q;
        rd_data[PIN_BIT]             = cfg_q.out_en ? cfg_q.out_val : pin_in;
        rd_data[ISTS_BIT +: NUM_STS] = sts_vec;
    end

    always_comb begin
        pad_oe  = cfg_q.out_en;
        pad_out = cfg_q.out_val;
        pending = (|sts_vec) & cfg_q.unmask;
    end

    // R8
    no_status_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vec == '0) |-> !pending);

    // R7
    disabled_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.irq_en && !sts_vec[0]) |=> !sts_vec[0]);

    // R5
    level_high_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.level && cfg_q.irq_en && cfg_q.pol == POL_HIGH && pin_in) |=> sts_vec[0]);

    // R12
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:ISTS_BIT+NUM_STS] == '0);
endmodule

// File: tb/test_gpio_pin_irq_unit.sv
module test_gpio_pin_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pad_oe, pad_out, pending;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    localparam logic [31:0] IEN  = 32'h08;
    localparam logic [31:0] UNM  = 32'h10;
    localparam logic [31:0] OE   = 32'h20;
    localparam logic [31:0] OV   = 32'h40;
    localparam logic [31:0] WEN  = 32'h80;
    localparam logic [31:0] CLRI = 32'h1000;
    localparam logic [31:0] CLRW = 32'h2000;

    always #5 clk = ~clk;

    gpio_pin_irq_unit i_gpio_pin_irq_unit (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pad_oe(pad_oe),
        .pad_out(pad_out), .pending(pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic exp;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 rd", rd_data, 32'h0);
        chk("R1 pending", {31'b0, pending}, 32'h0);
        chk("R1 oe", {31'b0, pad_oe}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R5 R6: sweep all encodings against all input pairs
        for (int lv = 0; lv < 2; lv++)
            for (int pol = 0; pol < 4; pol++)
                for (int a = 0; a < 2; a++)
                    for (int b = 0; b < 2; b++) begin
                        logic [31:0] base;
                        base = 32'(lv) | (32'(pol) << 1);
                        pin_in = a[0];
                        wr(base | CLRI | CLRW);
                        tick();
                        wr(base | IEN | UNM | CLRI);
                        pin_in = b[0];
                        tick();
                        if (lv == 1)
                            exp = (pol == 0) ? b[0] : (pol == 1) ? !b[0] : 1'b0;
                        else
                            exp = (pol == 0) ? (!a[0] && b[0]) :
                                  (pol == 1) ? (a[0] && !b[0]) :
                                  (pol == 2) ? (a[0] != b[0]) : 1'b0;
                        chk($sformatf("R2/R3/R4/R5/R6 sts lv%0d pol%0d %0d->%0d", lv, pol, a, b),
                            {31'b0, rd_data[12]}, {31'b0, exp});
                        chk($sformatf("R8 pending lv%0d pol%0d %0d->%0d", lv, pol, a, b),
                            {31'b0, pending}, {31'b0, exp});
                    end

        // R5: clear while active has no effect
        pin_in = 1'b0;
        wr(CLRI | CLRW);
        wr(32'h1 | IEN | UNM);
        pin_in = 1'b1;
        tick(); tick();
        wr(32'h1 | IEN | UNM | CLRI);
        chk("R5 clear while active", {31'b0, rd_data[12]}, 32'h1);
        pin_in = 1'b0;
        tick();
        wr(32'h1 | IEN | UNM | CLRI);
        chk("R5 clear after inactive", {31'b0, rd_data[12]}, 32'h0);

        // R7 and R9: disable keeps status, write of 0 keeps status
        wr(IEN | UNM);
        pin_in = 1'b1;
        tick();
        chk("R2 rise latched", {31'b0, rd_data[12]}, 32'h1);
        wr(UNM);
        chk("R7 disable keeps sts", {31'b0, rd_data[12]}, 32'h1);
        chk("R9 write zero keeps", {31'b0, pending}, 32'h1);
        wr(UNM | CLRI);
        chk("R9 w1c", {31'b0, rd_data[12]}, 32'h0);
        pin_in = 1'b0; tick();
        pin_in = 1'b1; tick();
        chk("R7 no latch disabled", {31'b0, rd_data[12]}, 32'h0);

        // R8: masked status does not pend
        pin_in = 1'b0;
        wr(IEN);
        pin_in = 1'b1; tick();
        chk("R8 masked sts", {31'b0, rd_data[12]}, 32'h1);
        chk("R8 masked pending", {31'b0, pending}, 32'h0);
        wr(IEN | UNM);
        chk("R8 unmasked pending", {31'b0, pending}, 32'h1);
        wr(CLRI);

        // R10: wake status
        pin_in = 1'b0;
        wr(WEN | UNM);
        pin_in = 1'b1; tick();
        chk("R10 wake sts", {30'b0, rd_data[13:12]}, 32'h2);
        chk("R10 wake pending", {31'b0, pending}, 32'h1);
        wr(WEN | UNM | CLRW);
        chk("R10 wake w1c", {31'b0, rd_data[13]}, 32'h0);

        // R11: pad and pin status
        pin_in = 1'b0;
        wr(OE | OV);
        chk("R11 oe", {30'b0, pad_oe, pad_out}, 32'h3);
        chk("R11 pin bit out", {31'b0, rd_data[8]}, 32'h1);
        wr(OE);
        chk("R11 pin bit low", {31'b0, rd_data[8]}, 32'h0);
        wr(32'h0);
        pin_in = 1'b1; tick();
        chk("R11 pin bit input", {31'b0, rd_data[8]}, 32'h1);
        chk("R11 oe off", {31'b0, pad_oe}, 32'h0);

        // R12: read-only bits
        wr(CLRI | CLRW);
        wr(32'hFFFF_CFFF);
        chk("R12 readback", rd_data, 32'h0000_01FF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule